// File: doc/BRIEF.md
# Deficiency-Based Binary Squaring Unit

This unit squares an N-bit unsigned operand without multiplying the operand by itself. It first takes the distance from the operand to the power-of-two base 2^N (the deficiency), squares that distance in an N-bit sub-squarer, and then builds the final square from two halves. The low half is the low N bits of the squared deficiency. The high half is the operand minus the deficiency, corrected by the upper bits of the squared deficiency. The identity behind it is A² = (A − D)·2^N + D², with D = 2^N − A.

The operand's top bit selects how the correction is applied. When that bit is 1, the difference A − D is not negative, and the upper bits of D² are added to it. When that bit is 0, the difference is negative, and its magnitude is taken away from the upper bits of D².

The datapath is purely combinational. A parameter can place one output register stage, with a valid flag, after it. The unit is meant for datapaths that need a square of a value held in a register, at widths from a few bits up to 32.

Top module: `defsq_unit`

## Requirements
- R1: The deficiency is the N-bit two's complement of the operand, so operand + deficiency ≡ 0 (mod 2^N); an operand of 0 gives a deficiency of 0.
- R2: Bits [N-1:0] of the square equal the low N bits of the squared deficiency, (2^N − A)² mod 2^N.
- R3: When operand bit N-1 is 1, bits [2N-1:N] of the square equal (A − D) plus the bits of D² above position N-1.
- R4: When operand bit N-1 is 0, bits [2N-1:N] of the square equal the bits of D² above position N-1 minus (D − A).
- R5: The 2N-bit output equals A·A for every N-bit operand A.
- R6: An operand of 0 gives an all-zero square. An operand of 1 gives a square of 1, even though its deficiency is 2^N − 1.
- R7: With the output register enabled, out_vld equals in_vld delayed by one clock. The square updates on a clock only when in_vld was high, and holds its value otherwise. With the register disabled, the square follows the operand within the same cycle and out_vld follows in_vld.
- R8: While rst_n is low, the registered outputs read out_vld = 0 and square = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 1 | Operand qualifier |
| operand | input | N | Unsigned value to square |
| out_vld | output | 1 | Result qualifier |
| square | output | 2N | Unsigned square of the operand |

## Verification
The bench builds the unit three times. N = 2, without the register, checks the smallest case, where 11 must give 1001. N = 8, with the register, makes every operand reachable, so both signs of A − D and the valid/hold timing are covered exhaustively. N = 32, without the register, reaches the widest carry terms: operand 1 with a deficiency of all ones, the midpoint 2^31 where D = A, and the all-ones operand. Directed corners and pseudo-random operands are added at this width.

// File: rtl/defsq_pkg.sv
package defsq_pkg;
  // Selects how the high-half correction is applied.
  typedef enum logic {
    HALF_SUB = 1'b0,  // operand below the midpoint: carry minus |A-D|
    HALF_ADD = 1'b1   // operand at or above the midpoint: (A-D) plus carry
  } hmode_t;
endpackage

// File: rtl/defsq_front.sv
module defsq_front #(
  parameter int N = 8
) (
  input  logic [N-1:0]         a_i,
  output logic [N-1:0]         defc_o,
  output logic [N-1:0]         mag_o,
  output defsq_pkg::hmode_t    mode_o
);
  import defsq_pkg::*;

  function automatic logic [N-1:0] f_twos(input logic [N-1:0] v);
    return ~v + {{(N-1){1'b0}}, 1'b1};
  endfunction

  // |A - D| with the sign carried separately by the mode.
  function automatic logic [N-1:0] f_gap(input logic [N-1:0] v,
                                         input logic [N-1:0] d,
                                         input hmode_t       m);
    return (m == HALF_ADD) ? (v - d) : (d - v);
  endfunction

  always_comb begin
    mode_o = a_i[N-1] ? HALF_ADD : HALF_SUB;
    defc_o = f_twos(a_i);
    mag_o  = f_gap(a_i, defc_o, mode_o);
  end
endmodule

// File: rtl/defsq_core.sv
module defsq_core #(
  parameter int N = 8
) (
  input  logic [N-1:0]   d_i,
  output logic [2*N-1:0] sq_o
);
  localparam int W2 = 2 * N;

  logic [W2-1:0] acc [0:N];

  assign acc[0] = '0;

  // Shift-and-add rows, one per deficiency bit.
  for (genvar i = 0; i < N; i++) begin : g_row
    logic [W2-1:0] row;
    assign row        = d_i[i] ? ({{N{1'b0}}, d_i} << i) : '0;
    assign acc[i + 1] = acc[i] + row;
  end

  assign sq_o = acc[N];
endmodule

// File: rtl/defsq_merge.sv
module defsq_merge #(
  parameter int N = 8
) (
  input  logic [2*N-1:0]       dsq_i,
  input  logic [N-1:0]         mag_i,
  input  defsq_pkg::hmode_t    mode_i,
  output logic [N-1:0]         carry_o,
  output logic [2*N-1:0]       sq_o
);
  import defsq_pkg::*;

  function automatic logic [N-1:0] f_high(input logic [N-1:0] cy,
                                          input logic [N-1:0] g,
                                          input hmode_t       m);
    return (m == HALF_ADD) ? (cy + g) : (cy - g);
  endfunction

  always_comb begin
    carry_o = dsq_i[2*N-1:N];
    sq_o    = {f_high(carry_o, mag_i, mode_i), dsq_i[N-1:0]};
  end
endmodule

// File: rtl/defsq_unit.sv
module defsq_unit #(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_vld,
  input  logic [N-1:0]   operand,
  output logic           out_vld,
  output logic [2*N-1:0] square
);
  import defsq_pkg::*;

  localparam int W2 = 2 * N;

  // Named internal events, visible to the bound checker.
  logic [N-1:0]  defc;
  logic [N-1:0]  mag;
  hmode_t        mode;
  logic [W2-1:0] dsq;
  logic [N-1:0]  carry;
  logic [W2-1:0] comb_sq;

  defsq_front #(.N(N)) u_front (
    .a_i    (operand),
    .defc_o (defc),
    .mag_o  (mag),
    .mode_o (mode)
  );

  defsq_core #(.N(N)) u_core (
    .d_i  (defc),
    .sq_o (dsq)
  );

  defsq_merge #(.N(N)) u_merge (
    .dsq_i   (dsq),
    .mag_i   (mag),
    .mode_i  (mode),
    .carry_o (carry),
    .sq_o    (comb_sq)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_vld <= 1'b0;
        square  <= '0;
      end else begin
        out_vld <= in_vld;
        if (in_vld) square <= comb_sq;
      end
    end
  end else begin : g_comb
    assign out_vld = in_vld;
    assign square  = comb_sq;
  end
endmodule

// File: rtl/defsq_chk.sv
module defsq_chk #(
  parameter int N       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_vld,
  input logic [N-1:0]   operand,
  input logic [N-1:0]   defc,
  input logic [N-1:0]   carry,
  input logic [2*N-1:0] comb_sq,
  input logic           out_vld,
  input logic [2*N-1:0] square
);
  localparam int W2 = 2 * N;

  logic [W2-1:0] ref_sq;
  logic [N-1:0]  sum_ad;
  assign ref_sq = {{N{1'b0}}, operand} * {{N{1'b0}}, operand};
  assign sum_ad = operand + defc;

  p_defic_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sum_ad == '0);

  p_low_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    comb_sq[N-1:0] == ref_sq[N-1:0]);

  p_high_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
    operand[N-1] |-> comb_sq[W2-1:N] == ref_sq[W2-1:N]);

  p_high_sub_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !operand[N-1] |-> comb_sq[W2-1:N] == ref_sq[W2-1:N]);

  p_zero_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (operand == '0) |-> (carry == '0 && comb_sq == '0));

  if (REG_OUT) begin : g_seq
    p_vld_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld == $past(in_vld));

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_vld) |-> $stable(square));

    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> square == $past(ref_sq));
  end
endmodule

bind defsq_unit defsq_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_vld  (in_vld),
  .operand (operand),
  .defc    (defc),
  .carry   (carry),
  .comb_sq (comb_sq),
  .out_vld (out_vld),
  .square  (square)
);

// File: tb/defsq_unit_test.sv
`timescale 1ns/1ps
module defsq_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // N = 8, registered
  logic        v8_in = 1'b0;
  logic [7:0]  a8 = '0;
  logic        v8_out;
  logic [15:0] s8;
  // N = 32, combinational
  logic        v32_in = 1'b0;
  logic [31:0] a32 = '0;
  logic        v32_out;
  logic [63:0] s32;
  // N = 2, combinational
  logic        v2_in = 1'b0;
  logic [1:0]  a2 = '0;
  logic        v2_out;
  logic [3:0]  s2;

  defsq_unit #(.N(8), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_vld(v8_in), .operand(a8),
    .out_vld(v8_out), .square(s8));
  defsq_unit #(.N(32), .REG_OUT(1'b0)) uut_w (
    .clk(clk), .rst_n(rst_n), .in_vld(v32_in), .operand(a32),
    .out_vld(v32_out), .square(s32));
  defsq_unit #(.N(2), .REG_OUT(1'b0)) uut_t (
    .clk(clk), .rst_n(rst_n), .in_vld(v2_in), .operand(a2),
    .out_vld(v2_out), .square(s2));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] msk(input int n);
    return (n >= 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << n) - 64'd1);
  endfunction

  // Checks the halves the deficiency way and the whole as a plain product.
  task automatic judge(input int n, input logic [63:0] a, input logic [63:0] sq);
    logic [63:0] d, dd, cy, hi, lo;
    d  = ((64'd1 << n) - a) & msk(n);
    dd = d * d;
    cy = (dd >> n) & msk(n);
    lo = dd & msk(n);
    if (a[n-1]) hi = ((a - d) + cy) & msk(n);
    else        hi = (cy - (d - a)) & msk(n);
    chk("R2 low half", sq & msk(n), lo);
    if (a[n-1]) chk("R3 high half add", (sq >> n) & msk(n), hi);
    else        chk("R4 high half sub", (sq >> n) & msk(n), hi);
    chk("R5 full square", sq, a * a);
  endtask

  task automatic t_reset;
    // R8: outputs held clear during reset
    @(negedge clk);
    chk("R8 out_vld in reset", {63'd0, v8_out}, 64'd0);
    chk("R8 square in reset", {48'd0, s8}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 out_vld after reset", {63'd0, v8_out}, 64'd0);
  endtask

  task automatic t_two_bit;
    // R5 smallest case: 11 -> 1001
    for (int i = 0; i < 4; i++) begin
      a2 = i[1:0];
      #1;
      judge(2, {62'd0, a2}, {60'd0, s2});
    end
    a2 = 2'b11;
    #1;
    chk("R5 two-bit example", {60'd0, s2}, 64'h9);
  endtask

  task automatic t_small_all;
    // R5/R7: every 8-bit operand through the register stage
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      a8 = i[7:0];
      v8_in = 1'b1;
      @(negedge clk);
      chk("R7 out_vld follows in_vld", {63'd0, v8_out}, 64'd1);
      judge(8, {56'd0, a8}, {48'd0, s8});
    end
  endtask

  task automatic t_hold;
    // R7: with in_vld low the square keeps its last value
    logic [15:0] kept;
    @(negedge clk);
    a8 = 8'd200;
    v8_in = 1'b1;
    @(negedge clk);
    kept = s8;
    chk("R7 capture", {48'd0, kept}, 64'd40000);
    v8_in = 1'b0;
    a8 = 8'd3;
    @(negedge clk);
    chk("R7 out_vld drops", {63'd0, v8_out}, 64'd0);
    a8 = 8'd77;
    @(negedge clk);
    chk("R7 square held", {48'd0, s8}, {48'd0, kept});
  endtask

  task automatic t_corners;
    // R1/R6: zero and one; deficiency is observed through the halves
    a32 = 32'd0;
    #1;
    chk("R6 zero operand", s32, 64'd0);
    chk("R1 zero deficiency gives zero low half", s32 & msk(32), 64'd0);
    a32 = 32'd1;
    #1;
    chk("R6 unit operand", s32, 64'd1);
    a32 = 32'h8000_0000;
    #1;
    judge(32, {32'd0, a32}, s32);
    a32 = 32'hFFFF_FFFF;
    #1;
    judge(32, {32'd0, a32}, s32);
    a32 = 32'h7FFF_FFFF;
    #1;
    judge(32, {32'd0, a32}, s32);
    v32_in = 1'b1;
    #1;
    chk("R7 comb out_vld", {63'd0, v32_out}, 64'd1);
  endtask

  task automatic t_wide_random;
    // R3/R4/R5: pseudo-random 32-bit operands
    for (int i = 0; i < 2000; i++) begin
      a32 = $urandom();
      #1;
      judge(32, {32'd0, a32}, s32);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd13));
    t_reset();
    t_two_bit();
    t_small_all();
    t_hold();
    t_corners();
    t_wide_random();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule